// File: doc/BRIEF.md
# PS/2 Serial Frame Receiver

This block takes the clock and data lines of a PS/2 keyboard or mouse and turns each 11-bit serial frame into a parallel byte. The device drives its clock at roughly 10 to 16.7 kHz. Data is only trustworthy while that clock is low. So the receiver does not latch a bit on the falling edge itself. It waits a fixed settling delay after each falling edge and samples then.

A frame is counted as finished only when the device clock rises after the eleventh bit. At that point the byte is presented for one system cycle, together with a flag that covers framing and parity.

An idle watchdog watches for the device clock staying high for longer than any bit period. When that happens it discards a partial frame, so a glitch or an interrupted transfer cannot misalign the frames that follow. All delays are derived from the system clock frequency, which is a parameter.

Top module: `ps2_frame_rx`

## Requirements
- R1: While reset is high and after it falls, `byte_valid_o` and `frame_err_o` are low and `byte_o` is 0. Reset also clears the bit counter and both timers, so a frame that was cut off by reset does not disturb the next frame.
- R2: A frame carries, in this order on the line:
  - line bit 0: a start bit of 0;
  - line bits 1 to 8: eight data bits, least significant first;
  - line bit 9: a parity bit that makes the nine data-plus-parity bits hold an odd count of ones;
  - line bit 10: a stop bit of 1.
  For every byte value, a well-formed frame yields `byte_o` equal to the data and `frame_err_o` low.
- R3: Each bit is sampled `SAMPLE_US` microseconds after the synchronised device clock falls. The delay is `(CLK_HZ/1000)*SAMPLE_US/1000` system cycles, and the default is 20 µs. The data level during the first part of the low phase and during the high phase has no effect on the result.
- R4: `byte_valid_o` is high for exactly one system cycle per frame. The pulse comes only after the device clock rises following the eleventh sampled bit, never before that edge. `byte_o` holds its value between pulses.
- R5: A start bit of 1 sets `frame_err_o` with the pulse.
- R6: A stop bit of 0 sets `frame_err_o` with the pulse.
- R7: An even count of ones across the eight data bits and the parity bit sets `frame_err_o` with the pulse.
- R8: If the device clock stays high for `IDLE_US` microseconds after a rising edge, the bit counter returns to zero. The delay is `(CLK_HZ/1000)*IDLE_US/1000` cycles, and the default is 100 µs. A complete frame that follows is then decoded correctly.
- R9: `frame_err_o` is high only during a `byte_valid_o` pulse. On an erroneous frame, `byte_o` still carries the eight received data bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ps2_clk_i | input | 1 | Device clock line, asynchronous |
| ps2_dat_i | input | 1 | Device data line, asynchronous |
| byte_valid_o | output | 1 | One-cycle strobe when a frame completes |
| byte_o | output | 8 | Received data byte |
| frame_err_o | output | 1 | Start, stop or parity fault, valid with the strobe |

## Verification
The bench builds the receiver with `CLK_HZ` set to 500 kHz. With that setting the sample delay is 10 cycles and the idle limit is 50 cycles, so a whole frame lasts only a few hundred cycles.

This makes a sweep of all 256 byte values practical. Each frame in the sweep drives the wrong data level just after the falling edge and random levels during the high phase, which exercises the sampling point. The short idle limit also lets a partial-frame recovery and a mid-frame reset be followed at once by a checked frame. Framing and parity faults are injected on bytes at both ends of the value range.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;

   localparam int unsigned FRAME_BITS = 11;
   localparam int unsigned DATA_BITS  = 8;
   localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);

   // Cycles for a delay of 'us' microseconds at 'hz'.
   function automatic int unsigned us_to_cycles(input int unsigned hz, input int unsigned us);
      return ((hz / 1000) * us) / 1000;
   endfunction

   // Frame fault: start high, stop low, or even ones over data plus parity.
   function automatic logic frame_fault(input logic [FRAME_BITS-1:0] f);
      return f[0] | ~f[FRAME_BITS-1] | ~(^f[DATA_BITS+1:1]);
   endfunction

endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic ps2_clk_i,
   input  logic ps2_dat_i,
   output logic clk_s_o,
   output logic dat_s_o,
   output logic fall_o,
   output logic rise_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ps2_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] clk_chain_q;
   logic [STAGES-1:0] dat_chain_q;
   logic              clk_prev_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         clk_chain_q <= '1;
         dat_chain_q <= '1;
         clk_prev_q  <= 1'b1;
      end else begin
         clk_chain_q <= {clk_chain_q[STAGES-2:0], ps2_clk_i};
         dat_chain_q <= {dat_chain_q[STAGES-2:0], ps2_dat_i};
         clk_prev_q  <= clk_chain_q[STAGES-1];
      end
   end

   assign clk_s_o = clk_chain_q[STAGES-1];
   assign dat_s_o = dat_chain_q[STAGES-1];
   assign fall_o  = clk_prev_q & ~clk_s_o;
   assign rise_o  = ~clk_prev_q & clk_s_o;
endmodule

// File: rtl/ps2_interval_timer.sv
module ps2_interval_timer #(
   parameter int unsigned TICKS = 10
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic restart_i,
   input  logic enable_i,
   output logic expire_o
);
   generate
      if (TICKS < 1) begin : g_bad_ticks
         $error("ps2_interval_timer: TICKS must be at least 1");
      end
   endgenerate

   localparam int unsigned CW = (TICKS < 2) ? 1 : $clog2(TICKS + 1);
   localparam logic [CW-1:0] FULL = CW'(TICKS);
   localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

   logic [CW-1:0] cnt_q;

   // Parked at FULL when idle; a restart starts a fresh interval.
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q <= FULL;
      end else if (restart_i) begin
         cnt_q <= '0;
      end else if (enable_i && cnt_q != FULL) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expire_o = enable_i & ~restart_i & (cnt_q == LAST);
endmodule

// File: rtl/ps2_frame_shifter.sv
module ps2_frame_shifter
   import ps2_rx_pkg::*;
(
   input  logic                 clk_i,
   input  logic                 rst_i,
   input  logic                 sample_i,
   input  logic                 dat_i,
   input  logic                 rise_i,
   input  logic                 idle_i,
   output logic [CNT_W-1:0]     bit_cnt_o,
   output logic                 valid_o,
   output logic [DATA_BITS-1:0] byte_o,
   output logic                 err_o
);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_BITS);

   logic [FRAME_BITS-1:0] sr_q;
   logic [CNT_W-1:0]      cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         sr_q    <= '0;
         cnt_q   <= '0;
         valid_o <= 1'b0;
         byte_o  <= '0;
         err_o   <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         err_o   <= 1'b0;
         if (idle_i) begin
            cnt_q <= '0;
         end else if (rise_i && cnt_q == LAST_CNT) begin
            valid_o <= 1'b1;
            byte_o  <= sr_q[DATA_BITS:1];
            err_o   <= frame_fault(sr_q);
            cnt_q   <= '0;
         end else if (sample_i && cnt_q != LAST_CNT) begin
            // First bit received ends up in bit 0 after eleven shifts.
            sr_q  <= {dat_i, sr_q[FRAME_BITS-1:1]};
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign bit_cnt_o = cnt_q;
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
   import ps2_rx_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 50_000_000,
   parameter int unsigned SAMPLE_US   = 20,
   parameter int unsigned IDLE_US     = 100,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic       ps2_clk_i,
   input  logic       ps2_dat_i,
   output logic       byte_valid_o,
   output logic [7:0] byte_o,
   output logic       frame_err_o
);
   localparam int unsigned SAMPLE_TICKS = us_to_cycles(CLK_HZ, SAMPLE_US);
   localparam int unsigned IDLE_TICKS   = us_to_cycles(CLK_HZ, IDLE_US);

   generate
      if (SAMPLE_TICKS < 1) begin : g_bad_sample
         $error("ps2_frame_rx: CLK_HZ too low for the sample delay");
      end
      if (IDLE_TICKS <= SAMPLE_TICKS) begin : g_bad_idle
         $error("ps2_frame_rx: idle limit must exceed the sample delay");
      end
   endgenerate

   logic             clk_s;
   logic             dat_s;
   logic             clk_fall;
   logic             clk_rise;
   logic             sample_go;
   logic             idle_fire;
   logic [CNT_W-1:0] bit_cnt;

   ps2_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .ps2_clk_i (ps2_clk_i),
      .ps2_dat_i (ps2_dat_i),
      .clk_s_o   (clk_s),
      .dat_s_o   (dat_s),
      .fall_o    (clk_fall),
      .rise_o    (clk_rise)
   );

   ps2_interval_timer #(.TICKS(SAMPLE_TICKS)) u_sample_tmr (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .restart_i (clk_fall),
      .enable_i  (1'b1),
      .expire_o  (sample_go)
   );

   ps2_interval_timer #(.TICKS(IDLE_TICKS)) u_idle_tmr (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .restart_i (clk_rise),
      .enable_i  (clk_s),
      .expire_o  (idle_fire)
   );

   ps2_frame_shifter u_shift (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .sample_i  (sample_go),
      .dat_i     (dat_s),
      .rise_i    (clk_rise),
      .idle_i    (idle_fire),
      .bit_cnt_o (bit_cnt),
      .valid_o   (byte_valid_o),
      .byte_o    (byte_o),
      .err_o     (frame_err_o)
   );
endmodule

// File: rtl/ps2_frame_rx_chk.sv
module ps2_frame_rx_chk
   import ps2_rx_pkg::*;
(
   input logic             clk_i,
   input logic             rst_i,
   input logic             rise_i,
   input logic             idle_i,
   input logic [CNT_W-1:0] bit_cnt_i,
   input logic             valid_i,
   input logic [7:0]       byte_i,
   input logic             err_i
);
   // R4: strobe lasts a single cycle
   a_r4_valid_single: assert property (@(posedge clk_i) disable iff (rst_i)
      valid_i |=> !valid_i);

   // R4: strobe follows a rising device clock edge
   a_r4_valid_after_rise: assert property (@(posedge clk_i) disable iff (rst_i)
      valid_i |-> $past(rise_i));

   // R4: byte holds between strobes
   a_r4_byte_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      !valid_i |-> $stable(byte_i));

   // R9: error flag only with the strobe
   a_r9_err_with_valid: assert property (@(posedge clk_i) disable iff (rst_i)
      err_i |-> valid_i);

   // R8: idle expiry empties the bit counter
   a_r8_idle_clears: assert property (@(posedge clk_i) disable iff (rst_i)
      idle_i |=> bit_cnt_i == '0);

   // R2: counter never passes the frame length
   a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (rst_i)
      bit_cnt_i <= CNT_W'(FRAME_BITS));
endmodule

bind ps2_frame_rx ps2_frame_rx_chk u_chk (
   .clk_i     (clk_i),
   .rst_i     (rst_i),
   .rise_i    (clk_rise),
   .idle_i    (idle_fire),
   .bit_cnt_i (bit_cnt),
   .valid_i   (byte_valid_o),
   .byte_i    (byte_o),
   .err_i     (frame_err_o)
);

// File: tb/ps2_frame_rx_bench.sv
module ps2_frame_rx_bench;
   localparam int CLK_PERIOD = 10;
   localparam int unsigned SYS_HZ = 500_000; // 10-cycle sample delay, 50-cycle idle limit
   localparam int HALF = 18;                 // device clock half period in cycles

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       pclk = 1'b1;
   logic       pdat = 1'b1;
   logic       vld;
   logic [7:0] rx_byte;
   logic       rx_err;

   int   checks = 0;
   int   errors = 0;
   int   vcount = 0;
   int   stray_err = 0;
   logic [7:0] last_byte = '0;
   logic       last_err = 1'b0;
   bit   done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ps2_frame_rx #(.CLK_HZ(SYS_HZ)) u_ps2_frame_rx (
      .clk_i        (clk),
      .rst_i        (rst),
      .ps2_clk_i    (pclk),
      .ps2_dat_i    (pdat),
      .byte_valid_o (vld),
      .byte_o       (rx_byte),
      .frame_err_o  (rx_err)
   );

   always @(negedge clk) begin
      if (vld) begin
         vcount++;
         last_byte = rx_byte;
         last_err  = rx_err;
      end
      if (rx_err && !vld) stray_err++;
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   function automatic logic [10:0] mk_frame(input logic [7:0] d, input bit start_one,
                                            input bit stop_zero, input bit par_flip);
      return {~stop_zero, (~^d) ^ par_flip, d, start_one};
   endfunction

   // Wrong level just after each fall, random level while high (R3).
   task automatic send(input logic [10:0] f, input int n);
      int v0;
      v0 = vcount;
      for (int i = 0; i < n; i++) begin
         pdat = ~f[i];
         pclk = 1'b0;
         cyc(4);
         pdat = f[i];
         cyc(HALF - 4);
         if (n == 11 && i == n - 1)
            check("R4 no strobe before final rising edge", vcount, v0);
         pclk = 1'b1;
         pdat = 1'($urandom);
         cyc(HALF);
      end
      pdat = 1'b1;
   endtask

   task automatic run(input string req, input logic [7:0] d, input bit s1,
                      input bit s0, input bit pf);
      int v0;
      v0 = vcount;
      send(mk_frame(d, s1, s0, pf), 11);
      cyc(10);
      check({req, " one strobe"}, vcount, v0 + 1);
      check({req, " byte"}, int'(last_byte), int'(d));
      check({req, " error flag"}, int'(last_err), int'(s1 | s0 | pf));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      cyc(5);
      check("R1 valid in reset", int'(vld), 0);
      check("R1 error in reset", int'(rx_err), 0);
      check("R1 byte in reset", int'(rx_byte), 0);
      rst = 1'b0;
      cyc(5);
      check("R1 valid after reset", int'(vld), 0);

      // R2 R3: every byte value, with noisy data outside the sample window
      for (int d = 0; d < 256; d++) run("R2 R3", 8'(d), 1'b0, 1'b0, 1'b0);

      // R5 R6 R7 R9: faults at both ends of the byte range
      run("R5 R9 start", 8'h00, 1'b1, 1'b0, 1'b0);
      run("R5 R9 start", 8'hA5, 1'b1, 1'b0, 1'b0);
      run("R6 R9 stop", 8'hFF, 1'b0, 1'b1, 1'b0);
      run("R6 R9 stop", 8'h3C, 1'b0, 1'b1, 1'b0);
      run("R7 R9 parity", 8'h00, 1'b0, 1'b0, 1'b1);
      run("R7 R9 parity", 8'hFF, 1'b0, 1'b0, 1'b1);
      run("R7 R9 parity", 8'h81, 1'b0, 1'b0, 1'b1);

      // R8: partial frame then a long quiet high line
      send(mk_frame(8'h5A, 1'b0, 1'b0, 1'b0), 5);
      cyc(80);
      run("R8 after idle", 8'h96, 1'b0, 1'b0, 1'b0);

      // R1: reset in the middle of a frame, next frame follows quickly
      send(mk_frame(8'hC3, 1'b0, 1'b0, 1'b0), 4);
      rst = 1'b1;
      cyc(3);
      rst = 1'b0;
      cyc(5);
      run("R1 after mid-frame reset", 8'h3C, 1'b0, 1'b0, 1'b0);

      check("R9 error outside strobe", stray_err, 0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule